// File: doc/BRIEF.md
# Burst Dimming Clock Selector

This block produces the burst enable that gates a lamp inverter during digital dimming. Two strap-style inputs set its behaviour. Each is a three-level pin that reaches the block already encoded on two bits. The mode strap selects one of three sources: an external dimming clock, a half-rate copy of an internal reference oscillator, or no source at all (analog dimming). The divider strap picks a division of 2, 4 or 8, which applies to either clock source. The chosen source is divided and emitted as a square burst enable. The burst rate should normally sit between roughly 95 Hz and 400 Hz, which keeps flicker and audible noise away. The external clock may run at up to 200 kHz.

In analog dimming the burst path is bypassed and the burst enable is held high. The external clock pin then serves a second purpose as a static polarity strap: a high level means brightness grows with the control voltage, and a low level reverses that. The polarity bit is exported for the analog path and reads conventional (1) in either digital mode. The external clock is asynchronous and passes through a synchroniser before its rising edges are counted. The internal oscillator arrives as a one-cycle tick in the block's own clock domain. Any change of either strap clears the divider, so the output restarts cleanly from a known phase and never emits a runt pulse.

Top module: `burst_dim_clk`

## Requirements
- R1: Mode strap encoding: `11` selects the external clock source, `00` selects the internal source, and `01` or `10` select analog dimming.
- R2: Divider strap encoding: `11` divides by 2, `01` or `10` divide by 4, and `00` divides by 8. After k source events counted since the last clear, with divisor N, `burst_o` is 1 exactly when (k mod N) >= N/2. This gives a 50% duty square wave with a period of N source events.
- R3: In external mode, each rising edge of `ext_clk_i` is one source event, and `ref_tick_i` has no effect on `burst_o`.
- R4: In internal mode, every second `ref_tick_i` pulse after a clear is one source event (the reference divided by two), and `ext_clk_i` has no effect on `burst_o`.
- R5: In analog mode, `burst_o` is held at 1.
- R6: In analog mode, `pol_o` follows the synchronised level of `ext_clk_i` (1 conventional, 0 reversed). In either digital mode `pol_o` is 1.
- R7: Any change of the decoded mode or divider clears the divider and the internal half-rate phase. `burst_o` is 0 from the cycle after the change and then follows R2 with k counted from zero.
- R8: While `rst` is high, `burst_o` is 0 and `pol_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk_i | input | 1 | Asynchronous external dimming clock; polarity strap in analog mode |
| ref_tick_i | input | 1 | One-cycle tick per internal reference oscillator period |
| mode_pin_i | input | 2 | Encoded three-level mode strap |
| div_pin_i | input | 2 | Encoded three-level divider strap |
| burst_o | output | 1 | Registered burst enable |
| pol_o | output | 1 | Registered dimming polarity |

## Verification
The bench aims at three kinds of fault: a mis-decoded strap, a miscounted source, and a divider that does not restart. It counts source events one at a time and compares `burst_o` after each event with the modulo rule. A design that dropped the half-rate stage, swapped two divisor encodings, or decoded `10` as low would drift from the expected waveform within a few events. The bench also injects reference ticks in external mode and toggles the external pin in internal mode, which exposes any source mux that leaks the unselected clock. It changes the straps in the middle of a burst period, so a divider that keeps its old count shows up as a high output, or as an early edge, after the change. Analog mode is checked with both strap levels, which catches a polarity bit that is inverted or left driven by the digital path.

// File: rtl/burst_dim_pkg.sv
package burst_dim_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_OPEN = 2'd1,
    LVL_HIGH = 2'd2
  } tri_lvl_e;

  typedef enum logic [1:0] {
    DM_ANALOG = 2'd0,
    DM_EXT    = 2'd1,
    DM_INT    = 2'd2
  } dim_mode_e;

  // Two-bit strap code: 00 low, 11 high, 01 and 10 open.
  function automatic tri_lvl_e tri_decode(input logic [1:0] code);
    case (code)
      2'b00:   return LVL_LOW;
      2'b11:   return LVL_HIGH;
      default: return LVL_OPEN;
    endcase
  endfunction

  function automatic dim_mode_e mode_of(input tri_lvl_e lvl);
    case (lvl)
      LVL_HIGH: return DM_EXT;
      LVL_LOW:  return DM_INT;
      default:  return DM_ANALOG;
    endcase
  endfunction

endpackage

// File: rtl/bdc_sync.sv
module bdc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o
);
  localparam int LEN = STAGES + 1;

  logic [LEN-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else     sr_q <= {sr_q[LEN-2:0], d_i};
  end

  assign lvl_o  = sr_q[STAGES-1];
  assign rise_o = sr_q[STAGES-1] & ~sr_q[STAGES];
endmodule

// File: rtl/bdc_src.sv
module bdc_src
  import burst_dim_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      clr_i,
  input  dim_mode_e mode_i,
  input  logic      ext_rise_i,
  input  logic      ref_tick_i,
  output logic      ev_o
);
  logic half_q;

  // Internal source: reference divided by two.
  always_ff @(posedge clk) begin
    if (rst || clr_i)                        half_q <= 1'b0;
    else if (mode_i == DM_INT && ref_tick_i) half_q <= ~half_q;
  end

  always_comb begin
    case (mode_i)
      DM_EXT:  ev_o = ext_rise_i & ~clr_i;
      DM_INT:  ev_o = ref_tick_i & half_q & ~clr_i;
      default: ev_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bdc_div.sv
module bdc_div #(
  parameter int CNT_W = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr_i,
  input  logic           analog_i,
  input  logic           ev_i,
  input  logic [CNT_W:0] div_n_i,
  output logic           burst_o
);
  localparam int NW = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [NW-1:0]    cnt_ext;
  logic [NW-1:0]    cnt_nxt;
  logic [NW-1:0]    last;
  logic [NW-1:0]    half;

  assign cnt_ext = {1'b0, cnt_q};
  assign last    = div_n_i - NW'(1);
  assign half    = div_n_i >> 1;
  assign cnt_nxt = (cnt_ext == last) ? '0 : cnt_ext + NW'(1);

  always_ff @(posedge clk) begin
    if (rst || clr_i)  cnt_q <= '0;
    else if (ev_i)     cnt_q <= cnt_nxt[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)           burst_o <= 1'b0;
    else if (clr_i)    burst_o <= 1'b0;
    else if (analog_i) burst_o <= 1'b1;
    else if (ev_i)     burst_o <= (cnt_nxt >= half);
  end
endmodule

// File: rtl/burst_dim_clk.sv
module burst_dim_clk
  import burst_dim_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_HIGH    = 2,
  parameter int DIV_OPEN    = 4,
  parameter int DIV_LOW     = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ext_clk_i,
  input  logic       ref_tick_i,
  input  logic [1:0] mode_pin_i,
  input  logic [1:0] div_pin_i,
  output logic       burst_o,
  output logic       pol_o
);
  localparam int DIV_MAX = (DIV_LOW > DIV_OPEN) ?
                           ((DIV_LOW > DIV_HIGH) ? DIV_LOW : DIV_HIGH) :
                           ((DIV_OPEN > DIV_HIGH) ? DIV_OPEN : DIV_HIGH);
  localparam int CNT_W = $clog2(DIV_MAX);

  dim_mode_e      mode_d, mode_q;
  tri_lvl_e       div_d, div_q;
  logic           clr;
  logic           is_analog;
  logic           ext_lvl, ext_rise, src_ev;
  logic [CNT_W:0] div_n;

  assign mode_d = mode_of(tri_decode(mode_pin_i));
  assign div_d  = tri_decode(div_pin_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= DM_ANALOG;
      div_q  <= LVL_OPEN;
    end else begin
      mode_q <= mode_d;
      div_q  <= div_d;
    end
  end

  // Strap change: divider restarts, source switches at this forced wrap.
  assign clr       = (mode_d != mode_q) || (div_d != div_q);
  assign is_analog = (mode_q == DM_ANALOG);

  always_comb begin
    case (div_q)
      LVL_HIGH: div_n = (CNT_W+1)'(DIV_HIGH);
      LVL_LOW:  div_n = (CNT_W+1)'(DIV_LOW);
      default:  div_n = (CNT_W+1)'(DIV_OPEN);
    endcase
  end

  bdc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_i    (ext_clk_i),
    .lvl_o  (ext_lvl),
    .rise_o (ext_rise)
  );

  bdc_src u_src (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (clr),
    .mode_i     (mode_q),
    .ext_rise_i (ext_rise),
    .ref_tick_i (ref_tick_i),
    .ev_o       (src_ev)
  );

  bdc_div #(.CNT_W(CNT_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (clr),
    .analog_i (is_analog),
    .ev_i     (src_ev),
    .div_n_i  (div_n),
    .burst_o  (burst_o)
  );

  always_ff @(posedge clk) begin
    if (rst)            pol_o <= 1'b1;
    else if (is_analog) pol_o <= ext_lvl;
    else                pol_o <= 1'b1;
  end
endmodule

// File: rtl/bdc_chk.sv
module bdc_chk (
  input logic clk,
  input logic rst,
  input logic clr,
  input logic is_analog,
  input logic src_ev,
  input logic burst_o,
  input logic pol_o
);
  assert_reset_R8: assert property (@(posedge clk)
    rst |=> (!burst_o && pol_o));

  assert_clear_low_R7: assert property (@(posedge clk) disable iff (rst)
    clr |=> !burst_o);

  assert_analog_high_R5: assert property (@(posedge clk) disable iff (rst)
    (is_analog && !clr) |=> burst_o);

  assert_digital_pol_R6: assert property (@(posedge clk) disable iff (rst)
    !is_analog |=> pol_o);

  assert_hold_no_event_R2: assert property (@(posedge clk) disable iff (rst)
    (!clr && !src_ev && !is_analog) |=> $stable(burst_o));
endmodule

bind burst_dim_clk bdc_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .clr       (clr),
  .is_analog (is_analog),
  .src_ev    (src_ev),
  .burst_o   (burst_o),
  .pol_o     (pol_o)
);

// File: tb/tb_burst_dim_clk.sv
module tb_burst_dim_clk;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_clk_i = 1'b0;
  logic       ref_tick_i = 1'b0;
  logic [1:0] mode_pin_i = 2'b01;
  logic [1:0] div_pin_i = 2'b01;
  logic       burst_o, pol_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  burst_dim_clk dut (
    .clk(clk), .rst(rst), .ext_clk_i(ext_clk_i), .ref_tick_i(ref_tick_i),
    .mode_pin_i(mode_pin_i), .div_pin_i(div_pin_i),
    .burst_o(burst_o), .pol_o(pol_o)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit got, input bit exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  function automatic int div_of(input logic [1:0] p);
    if (p == 2'b11) return 2;
    if (p == 2'b00) return 8;
    return 4;
  endfunction

  function automatic bit exp_burst(input int k, input int n);
    return (k % n) >= (n / 2);
  endfunction

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Pass through analog so the digital target always starts from a clear.
  task automatic set_cfg(input logic [1:0] m, input logic [1:0] d);
    @(negedge clk);
    ext_clk_i = 1'b0; mode_pin_i = 2'b01; div_pin_i = 2'b01;
    wait_neg(5);
    mode_pin_i = m; div_pin_i = d;
    wait_neg(3);
  endtask

  task automatic ext_event(input bit noise);
    @(negedge clk); ext_clk_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      ref_tick_i = noise ? 1'($urandom % 2) : 1'b0;
      @(negedge clk);
    end
    ext_clk_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      ref_tick_i = noise ? 1'($urandom % 2) : 1'b0;
      @(negedge clk);
    end
    ref_tick_i = 1'b0;
    wait_neg(1);
  endtask

  task automatic int_tick(input bit noise);
    @(negedge clk); ref_tick_i = 1'b1;
    if (noise) ext_clk_i = 1'($urandom % 2);
    @(negedge clk); ref_tick_i = 1'b0;
    if (noise) ext_clk_i = 1'($urandom % 2);
    wait_neg(3);
  endtask

  initial begin
    void'($urandom(32'h5eed_b00f));
    // R8: reset values
    wait_neg(3);
    chk(burst_o, 1'b0, "R8 burst in reset");
    chk(pol_o, 1'b1, "R8 pol in reset");
    rst = 1'b0;

    // R5/R6/R1: analog with code 10, polarity strap
    mode_pin_i = 2'b10; ext_clk_i = 1'b1; wait_neg(6);
    chk(burst_o, 1'b1, "R5 analog(10) burst high");
    chk(pol_o, 1'b1, "R6 analog strap high");
    ext_clk_i = 1'b0; wait_neg(6);
    chk(pol_o, 1'b0, "R6 analog strap low");
    chk(burst_o, 1'b1, "R5 analog burst ignores strap");
    mode_pin_i = 2'b01; wait_neg(4);
    chk(pol_o, 1'b0, "R1 analog(01) strap low");

    // R6: digital mode forces conventional polarity with pin low
    set_cfg(2'b11, 2'b11);
    chk(pol_o, 1'b1, "R6 digital pol forced");
    chk(burst_o, 1'b0, "R7 burst low after change");

    // R7: divider change mid-period
    set_cfg(2'b11, 2'b00);
    for (int k = 1; k <= 5; k++) begin
      ext_event(1'b0);
      chk(burst_o, exp_burst(k, 8), "R2 ext div8");
    end
    @(negedge clk); div_pin_i = 2'b11; wait_neg(2);
    chk(burst_o, 1'b0, "R7 div change clears");
    for (int k = 1; k <= 3; k++) begin
      ext_event(1'b0);
      chk(burst_o, exp_burst(k, 2), "R7 restart div2");
    end

    // R7: mode change ext -> int mid-period
    set_cfg(2'b11, 2'b01);
    for (int k = 1; k <= 3; k++) ext_event(1'b0);
    chk(burst_o, exp_burst(3, 4), "R3 ext div4 three events");
    @(negedge clk); mode_pin_i = 2'b00; wait_neg(2);
    chk(burst_o, 1'b0, "R7 mode change clears");
    for (int t = 1; t <= 8; t++) begin
      int_tick(1'b0);
      chk(burst_o, exp_burst(t / 2, 4), "R4 int restart div4");
    end

    // Random mix: R1-type strap codes, R2, R3 and R4 with noise on the idle source
    for (int it = 0; it < 30; it++) begin
      logic [1:0] m, d;
      int n, ev;
      m  = ($urandom % 2) ? 2'b11 : 2'b00;
      d  = 2'($urandom % 4);
      n  = div_of(d);
      ev = 1 + int'($urandom % 18);
      set_cfg(m, d);
      chk(burst_o, 1'b0, "R7 start low");
      if (m == 2'b11) begin
        for (int k = 1; k <= ev; k++) begin
          ext_event(1'b1);
          chk(burst_o, exp_burst(k, n), "R3 ext random");
        end
      end else begin
        for (int t = 1; t <= 2 * ev; t++) begin
          int_tick(1'b1);
          chk(burst_o, exp_burst(t / 2, n), "R4 int random");
        end
        chk(pol_o, 1'b1, "R6 int pol");
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule